// File: doc/BRIEF.md
# Binary-Weight Dual-MAC Output Channel Array

This block does the arithmetic for one output channel of a small convolution engine. A full core places sixteen of them side by side. Two operand streams feed it, and each stream stands for one input channel. On each accepted beat, each stream supplies one binary weight and a 2x2 patch of four unsigned 4-bit activations. The weight from a stream is broadcast to all four pixel lanes.

Each of the four lanes is a dual-MAC. It turns each activation into a signed product by sign selection: the activation is kept or negated according to the weight bit. The lane adds the two products and accumulates the sum into a signed 10-bit register that saturates instead of wrapping. A clear input empties the accumulators at the start of an output tile. A drain pulse copies all four results to the output, marked valid for one cycle.

Top module: `bwmac_channel`

## Requirements
- R1: After reset, res_valid_o is 0, res_o is all zeros and all four accumulators read zero.
- R2: a_ready_o equals b_valid_i AND NOT clear_i, and b_ready_o equals a_valid_i AND NOT clear_i. A beat is consumed only in a cycle where both valid inputs are high and clear_i is low. In any other cycle the accumulators keep their value.
- R3: A weight bit of 1 means +1 and a bit of 0 means -1. Each activation is unsigned, and lane k takes bits [4k+3:4k] of a_act_i and of b_act_i.
- R4: On a consumed beat, each lane adds the weighted activation of stream A and the weighted activation of stream B to its accumulator. The new value is visible at the next edge.
- R5: An accumulation that would exceed +511 leaves the accumulator at +511.
- R6: An accumulation that would fall below -512 leaves the accumulator at -512.
- R7: clear_i zeroes all four accumulators at the next edge. clear_i takes priority over a beat presented in the same cycle, and that beat is neither consumed nor accumulated.
- R8: A cycle with drain_i high makes res_valid_o high in the following cycle. In that cycle res_o holds each lane's accumulator value as it stood before that cycle's update, signed 10-bit, with lane k at bits [10k+9:10k].
- R9: res_valid_o is high only in the cycle after a drain. res_o keeps its value until the next drain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_valid_i | input | 1 | Stream A operands valid |
| a_ready_o | output | 1 | Stream A beat accepted |
| a_wgt_i | input | 1 | Stream A binary weight |
| a_act_i | input | 16 | Stream A 2x2 activation patch, 4 bits per lane |
| b_valid_i | input | 1 | Stream B operands valid |
| b_ready_o | output | 1 | Stream B beat accepted |
| b_wgt_i | input | 1 | Stream B binary weight |
| b_act_i | input | 16 | Stream B 2x2 activation patch, 4 bits per lane |
| clear_i | input | 1 | Zero all accumulators |
| drain_i | input | 1 | Copy accumulators to the result output |
| res_valid_o | output | 1 | Result valid, one cycle |
| res_o | output | 40 | Four signed 10-bit lane results |

## Verification
The assertions assume that clear_i, drain_i and both valid inputs are known and change only between clock edges. They also assume that streams rise valid without waiting for ready, because ready for one stream depends on the other stream's valid. The bench drives every input on the falling edge and raises valids freely, so valids often stand alone to exercise the pairing rule. Clear and drain are applied on their own, together, and together with live beats. Long runs of extreme activations push every lane against both saturation limits.

// File: rtl/bwmac_pkg.sv
package bwmac_pkg;
  localparam int unsigned ACT_W   = 4;
  localparam int unsigned ACC_W   = 10;
  localparam int unsigned NUM_PIX = 4;

  typedef enum logic {
    WGT_NEG = 1'b0,
    WGT_POS = 1'b1
  } wgt_e;
endpackage

// File: rtl/bwmac_sign_sel.sv
module bwmac_sign_sel #(
  parameter int unsigned ACT_W  = 4,
  localparam int unsigned PROD_W = ACT_W + 1
) (
  input  logic [ACT_W-1:0]         act_i,
  input  logic                     wgt_i,
  output logic signed [PROD_W-1:0] prod_o
);
  import bwmac_pkg::*;

  logic signed [PROD_W-1:0] act_ext;
  assign act_ext = $signed({1'b0, act_i});

  // binary weight: keep or negate, no multiplier
  always_comb begin
    if (wgt_e'(wgt_i) == WGT_POS) prod_o = act_ext;
    else                          prod_o = -act_ext;
  end
endmodule

// File: rtl/bwmac_lane.sv
module bwmac_lane #(
  parameter int unsigned ACT_W = 4,
  parameter int unsigned ACC_W = 10,
  localparam int unsigned PROD_W = ACT_W + 1,
  localparam int unsigned SUM_W  = ACC_W + 1
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    fire_i,
  input  logic                    clear_i,
  input  logic [ACT_W-1:0]        act_a_i,
  input  logic                    wgt_a_i,
  input  logic [ACT_W-1:0]        act_b_i,
  input  logic                    wgt_b_i,
  output logic signed [ACC_W-1:0] acc_o
);
  logic signed [PROD_W-1:0] prod_a, prod_b;
  logic signed [SUM_W-1:0]  sum;
  logic signed [ACC_W-1:0]  acc_q, acc_d;
  logic                     ovf;

  bwmac_sign_sel #(.ACT_W(ACT_W)) u_sel_a (.act_i(act_a_i), .wgt_i(wgt_a_i), .prod_o(prod_a));
  bwmac_sign_sel #(.ACT_W(ACT_W)) u_sel_b (.act_i(act_b_i), .wgt_i(wgt_b_i), .prod_o(prod_b));

  // one guard bit covers the per-beat increment (|inc| < 2**(ACC_W-1))
  assign sum = SUM_W'(acc_q) + SUM_W'(prod_a) + SUM_W'(prod_b);
  assign ovf = sum[SUM_W-1] ^ sum[SUM_W-2];

  always_comb begin
    if (ovf) acc_d = {sum[SUM_W-1], {(ACC_W-1){~sum[SUM_W-1]}}};
    else     acc_d = sum[ACC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (clear_i) acc_q <= '0;
    else if (fire_i)  acc_q <= acc_d;
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/bwmac_channel.sv
module bwmac_channel #(
  parameter int unsigned ACT_W   = bwmac_pkg::ACT_W,
  parameter int unsigned ACC_W   = bwmac_pkg::ACC_W,
  parameter int unsigned NUM_PIX = bwmac_pkg::NUM_PIX,
  localparam int unsigned PATCH_W = NUM_PIX * ACT_W,
  localparam int unsigned RES_W   = NUM_PIX * ACC_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               a_valid_i,
  output logic               a_ready_o,
  input  logic               a_wgt_i,
  input  logic [PATCH_W-1:0] a_act_i,
  input  logic               b_valid_i,
  output logic               b_ready_o,
  input  logic               b_wgt_i,
  input  logic [PATCH_W-1:0] b_act_i,
  input  logic               clear_i,
  input  logic               drain_i,
  output logic               res_valid_o,
  output logic [RES_W-1:0]   res_o
);
  logic             fire;
  logic [RES_W-1:0] acc_flat;
  logic [RES_W-1:0] res_q;
  logic             res_valid_q;

  // a beat needs both input channels at once; clear blocks it
  assign a_ready_o = b_valid_i & ~clear_i;
  assign b_ready_o = a_valid_i & ~clear_i;
  assign fire      = a_valid_i & b_valid_i & ~clear_i;

  for (genvar k = 0; k < NUM_PIX; k++) begin : g_lane
    logic signed [ACC_W-1:0] lane_acc;
    bwmac_lane #(.ACT_W(ACT_W), .ACC_W(ACC_W)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .fire_i  (fire),
      .clear_i (clear_i),
      .act_a_i (a_act_i[k*ACT_W +: ACT_W]),
      .wgt_a_i (a_wgt_i),
      .act_b_i (b_act_i[k*ACT_W +: ACT_W]),
      .wgt_b_i (b_wgt_i),
      .acc_o   (lane_acc)
    );
    assign acc_flat[k*ACC_W +: ACC_W] = lane_acc;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q       <= '0;
      res_valid_q <= 1'b0;
    end else begin
      res_valid_q <= drain_i;
      if (drain_i) res_q <= acc_flat;
    end
  end

  assign res_o       = res_q;
  assign res_valid_o = res_valid_q;
endmodule

// File: rtl/bwmac_channel_chk.sv
module bwmac_channel_chk #(
  parameter int unsigned NUM_PIX = 4,
  parameter int unsigned ACC_W   = 10,
  localparam int unsigned RES_W  = NUM_PIX * ACC_W
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             a_valid_i,
  input logic             a_ready_o,
  input logic             b_valid_i,
  input logic             b_ready_o,
  input logic             clear_i,
  input logic             drain_i,
  input logic             res_valid_o,
  input logic [RES_W-1:0] res_o,
  input logic [RES_W-1:0] acc_flat
);
  assert_paired_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_valid_i && a_ready_o) |-> (b_valid_i && b_ready_o));

  assert_idle_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clear_i && !(a_valid_i && a_ready_o)) |=> $stable(acc_flat));

  assert_clear_zeroes_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (acc_flat == '0));

  assert_drain_valid_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_i |=> res_valid_o);

  assert_no_spurious_valid_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drain_i |=> (!res_valid_o && $stable(res_o)));
endmodule

bind bwmac_channel bwmac_channel_chk #(.NUM_PIX(NUM_PIX), .ACC_W(ACC_W)) u_chk (.*);

// File: tb/bwmac_channel_tb.sv
module bwmac_channel_tb;
  localparam int NP = 4;
  localparam int AW = 4;
  localparam int CW = 10;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic a_valid = 0, b_valid = 0, a_wgt = 0, b_wgt = 0, clr = 0, drn = 0;
  logic [NP*AW-1:0] a_act = '0, b_act = '0;
  logic a_ready, b_ready, res_valid;
  logic [NP*CW-1:0] res;

  int errors = 0;
  int checks = 0;
  string tag = "R1";

  int m_acc [NP];
  int m_res [NP];
  bit m_rv;

  always #4 clk = ~clk;

  bwmac_channel u_dut (
    .clk_i(clk), .rst_ni(rst_ni),
    .a_valid_i(a_valid), .a_ready_o(a_ready), .a_wgt_i(a_wgt), .a_act_i(a_act),
    .b_valid_i(b_valid), .b_ready_o(b_ready), .b_wgt_i(b_wgt), .b_act_i(b_act),
    .clear_i(clr), .drain_i(drn), .res_valid_o(res_valid), .res_o(res)
  );

  task automatic check(input bit ok, input string t, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", t, act, exp);
    end
  endtask

  function automatic logic [NP*CW-1:0] exp_res();
    logic [NP*CW-1:0] v;
    for (int k = 0; k < NP; k++) v[k*CW +: CW] = CW'(m_res[k]);
    return v;
  endfunction

  function automatic int sat(input int v);
    if (v > 511) return 511;
    if (v < -512) return -512;
    return v;
  endfunction

  // drive at negedge, check ready, advance the model, check outputs one edge later
  task automatic cyc(input bit av, input bit bv, input bit aw, input bit bw,
                     input logic [NP*AW-1:0] aa, input logic [NP*AW-1:0] ba,
                     input bit c, input bit d);
    int nacc [NP];
    a_valid = av; b_valid = bv; a_wgt = aw; b_wgt = bw;
    a_act = aa; b_act = ba; clr = c; drn = d;
    #1;
    check(a_ready == (bv && !c), "R2 a_ready", 64'(a_ready), 64'(bv && !c));
    check(b_ready == (av && !c), "R2 b_ready", 64'(b_ready), 64'(av && !c));
    for (int k = 0; k < NP; k++) begin
      int pa, pb;
      pa = aw ? int'(aa[k*AW +: AW]) : -int'(aa[k*AW +: AW]);
      pb = bw ? int'(ba[k*AW +: AW]) : -int'(ba[k*AW +: AW]);
      if (c)              nacc[k] = 0;
      else if (av && bv)  nacc[k] = sat(m_acc[k] + pa + pb);
      else                nacc[k] = m_acc[k];
    end
    if (d) for (int k = 0; k < NP; k++) m_res[k] = m_acc[k];
    m_rv = d;
    for (int k = 0; k < NP; k++) m_acc[k] = nacc[k];
    @(negedge clk);
    check(res_valid == m_rv, {tag, " res_valid"}, 64'(res_valid), 64'(m_rv));
    check(res == exp_res(), {tag, " res"}, 64'(res), 64'(exp_res()));
  endtask

  task automatic idle(); cyc(0, 0, 0, 0, '0, '0, 0, 0); endtask
  task automatic drain(); cyc(0, 0, 0, 0, '0, '0, 0, 1); endtask

  initial begin
    for (int k = 0; k < NP; k++) begin m_acc[k] = 0; m_res[k] = 0; end
    m_rv = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1: reset state
    tag = "R1";
    check(res_valid == 1'b0, "R1 res_valid", 64'(res_valid), 0);
    check(res == '0, "R1 res", 64'(res), 0);
    drain();
    idle();

    // R3 / R4: directed sign selection per lane
    tag = "R3";
    cyc(1, 1, 1, 0, 16'h4321, 16'h1110, 0, 0);   // lanes 1-0,2-1,3-1,4-1
    drain();
    idle();
    tag = "R4";
    cyc(1, 1, 0, 0, 16'hF0A5, 16'h0123, 0, 0);
    cyc(1, 1, 1, 1, 16'h7777, 16'h8888, 0, 1);
    drain();

    // R2: unpaired valids change nothing
    tag = "R2";
    repeat (3) cyc(1, 0, 1, 1, 16'hFFFF, 16'hFFFF, 0, 0);
    repeat (3) cyc(0, 1, 0, 0, 16'hFFFF, 16'hFFFF, 0, 0);
    drain();

    // R7: clear wins over a live beat
    tag = "R7";
    cyc(1, 1, 1, 1, 16'h9999, 16'h9999, 1, 0);
    drain();
    cyc(1, 1, 1, 0, 16'h5555, 16'h2222, 1, 1);
    drain();

    // R5: positive saturation
    tag = "R5";
    repeat (25) cyc(1, 1, 1, 1, 16'hFFFF, 16'hFFFF, 0, 0);
    drain();
    cyc(1, 1, 1, 0, 16'h0001, 16'h0000, 0, 1);
    drain();

    // R6: negative saturation
    tag = "R6";
    cyc(0, 0, 0, 0, '0, '0, 1, 0);
    repeat (25) cyc(1, 1, 0, 0, 16'hFFFF, 16'hFFFF, 0, 0);
    drain();
    cyc(1, 1, 0, 1, 16'hF00F, 16'h0F0F, 0, 1);
    drain();

    // R8 / R9: random mix with drains, clears and gaps
    tag = "R8";
    for (int i = 0; i < 600; i++) begin
      if (i == 300) tag = "R9";
      cyc($urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0,
          1'($urandom), 1'($urandom), 16'($urandom), 16'($urandom),
          $urandom_range(0, 40) == 0, $urandom_range(0, 5) == 0);
    end
    drain();
    repeat (3) idle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule